// File: doc/BRIEF.md
# Steering target resolver

This block picks where a read of a replicated register must be steered so that it lands on a unit that is present and powered. An offset is compared in parallel against a set of address-range tables, one table per steering class. The highest-priority class that holds the offset picks the rule that turns the unit-enable masks into a group ID and an instance ID. An offset that no class holds gets the programmable default pair instead.

The enable inputs are a 3-bit L3 fuse field, a per-DSS enable vector and a per-memory-slice L3 enable vector. The range tables are parameters, and each range is inclusive at both ends. A range whose start is above its end never matches, which is how an unused table entry is written. The result is registered by default. Setting `OUT_REG` to 0 makes it purely combinational.

Top module: `steer_resolver`

## Requirements
- R1: An offset is held by a range when start <= offset <= end. Both ends are included, and the offsets one below the start and one above the end fall outside.
- R2: The class codes on `class_o` are 0 bank, 1 memory slice, 2 near-cache, 3 DSS, 4 fixed-zero and 7 none. When several classes hold the offset, the lowest code wins.
- R3: When no class holds the offset, `hit_o` is 0, `class_o` is 7, and the group and instance are `dflt_group_i` and `dflt_inst_i`.
- R4: Bank class: the group is 0. Fuse bit i enables banks 2i and 2i+1, and the instance is the lowest enabled bank number.
- R5: Memory-slice class: the group is the lowest enabled slice and the instance is 0. Slice m is enabled when `meml3_en_i[m]` is set or any of DSS 4m..4m+3 is enabled.
- R6: Near-cache class: the group is twice the lowest enabled memory slice and the instance is 0.
- R7: DSS class: take the lowest enabled DSS index. The group is that index divided by 4 and the instance is the remainder.
- R8: Fixed-zero class: the group and instance are 0 and `err_o` is 0, whatever the masks hold.
- R9: If the class that decided has an all-zero mask, `err_o` is 1 and the unit index used is 0. In every other case `err_o` is 0.
- R10: With `OUT_REG`=1, outputs show the result for the inputs sampled at the previous rising clock edge. During reset they are 0, except `class_o`, which is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| offset_i | input | ADDR_W (24) | Register offset to resolve |
| l3_fuse_i | input | L3_FUSE_W (3) | L3 fuse field, each bit enabling a bank pair |
| dss_en_i | input | NUM_DSS (16) | Per-DSS enable |
| meml3_en_i | input | NUM_MSLICE (4) | Per-memory-slice L3 enable |
| dflt_group_i | input | GID_W (6) | Default group for unmatched offsets |
| dflt_inst_i | input | IID_W (6) | Default instance for unmatched offsets |
| hit_o | output | 1 | Some class held the offset |
| class_o | output | 3 | Deciding class code |
| group_o | output | GID_W (6) | Steering group ID |
| inst_o | output | IID_W (6) | Steering instance ID |
| err_o | output | 1 | Deciding class had no enabled unit |

## Verification
Every result is due exactly one rising edge after the inputs that produce it. The driver changes inputs on a falling edge and tags each expected item with the cycle number in which it falls due. The monitor takes items off the queue only when their tag equals the current cycle, and it samples just after the following falling edge, halfway between register updates. Back-to-back stimuli that change on every cycle show that no result arrives early or late and that no result leaks into the next cycle's slot.

// File: rtl/steer_pkg.sv
`timescale 1ns/1ps
package steer_pkg;
  localparam int NCLS = 5;

  typedef enum logic [2:0] {
    CLS_BANK  = 3'd0,
    CLS_MSL   = 3'd1,
    CLS_NCACH = 3'd2,
    CLS_DSS   = 3'd3,
    CLS_ZERO  = 3'd4,
    CLS_NONE  = 3'd7
  } steer_cls_e;

  // two ranges per class, class 0 in the low slice; lo > hi marks an unused slot
  localparam logic [NCLS*2*24-1:0] DEF_RNG_LO = {
    24'h00B000, 24'h004000,
    24'h009680, 24'h005500,
    24'h00D800, 24'h00B000,
    24'h00E900, 24'h00DD00,
    24'hFFFFFF, 24'h00B100
  };
  localparam logic [NCLS*2*24-1:0] DEF_RNG_HI = {
    24'h00B3FF, 24'h004AFF,
    24'h0096FF, 24'h007FFF,
    24'h00D8FF, 24'h00B0FF,
    24'h00FFFF, 24'h00DDFF,
    24'h000000, 24'h00B3FF
  };
endpackage

// File: rtl/steer_range_match.sv
`timescale 1ns/1ps
module steer_range_match #(
  parameter int ADDR_W  = 24,
  parameter int NUM_RNG = 2,
  parameter logic [NUM_RNG*ADDR_W-1:0] LO = '0,
  parameter logic [NUM_RNG*ADDR_W-1:0] HI = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic [NUM_RNG-1:0] rng_hit;

  for (genvar r = 0; r < NUM_RNG; r++) begin : g_rng
    localparam logic [ADDR_W-1:0] R_LO = LO[r*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] R_HI = HI[r*ADDR_W +: ADDR_W];
    assign rng_hit[r] = (addr_i >= R_LO) && (addr_i <= R_HI);
  end

  assign hit_o = |rng_hit;
endmodule

// File: rtl/steer_first_set.sv
`timescale 1ns/1ps
module steer_first_set #(
  parameter int W     = 8,
  parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             none_o
);
  always_comb begin
    idx_o  = '0;
    none_o = 1'b1;
    for (int k = W - 1; k >= 0; k--) begin
      if (vec_i[k]) begin
        idx_o  = IDX_W'(k);
        none_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/steer_unit_masks.sv
`timescale 1ns/1ps
module steer_unit_masks #(
  parameter int L3_FUSE_W  = 3,
  parameter int NUM_DSS    = 16,
  parameter int NUM_MSLICE = 4,
  localparam int BANKS     = 2 * L3_FUSE_W,
  localparam int DSS_PER_Q = NUM_DSS / NUM_MSLICE
) (
  input  logic [L3_FUSE_W-1:0]  l3_fuse_i,
  input  logic [NUM_DSS-1:0]    dss_en_i,
  input  logic [NUM_MSLICE-1:0] meml3_en_i,
  output logic [BANKS-1:0]      bank_en_o,
  output logic [NUM_MSLICE-1:0] msl_en_o
);
  for (genvar i = 0; i < L3_FUSE_W; i++) begin : g_bank
    assign bank_en_o[2*i]   = l3_fuse_i[i];
    assign bank_en_o[2*i+1] = l3_fuse_i[i];
  end

  for (genvar m = 0; m < NUM_MSLICE; m++) begin : g_msl
    assign msl_en_o[m] = meml3_en_i[m] | (|dss_en_i[m*DSS_PER_Q +: DSS_PER_Q]);
  end
endmodule

// File: rtl/steer_resolver.sv
`timescale 1ns/1ps
module steer_resolver
  import steer_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int GID_W       = 6,
  parameter int IID_W       = 6,
  parameter int L3_FUSE_W   = 3,
  parameter int NUM_DSS     = 16,
  parameter int NUM_MSLICE  = 4,
  parameter int DSS_PER_GRP = 4,
  parameter int NUM_RNG     = 2,
  parameter bit OUT_REG     = 1'b1,
  parameter logic [NCLS*NUM_RNG*ADDR_W-1:0] RNG_LO = DEF_RNG_LO,
  parameter logic [NCLS*NUM_RNG*ADDR_W-1:0] RNG_HI = DEF_RNG_HI
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     offset_i,
  input  logic [L3_FUSE_W-1:0]  l3_fuse_i,
  input  logic [NUM_DSS-1:0]    dss_en_i,
  input  logic [NUM_MSLICE-1:0] meml3_en_i,
  input  logic [GID_W-1:0]      dflt_group_i,
  input  logic [IID_W-1:0]      dflt_inst_i,
  output logic                  hit_o,
  output logic [2:0]            class_o,
  output logic [GID_W-1:0]      group_o,
  output logic [IID_W-1:0]      inst_o,
  output logic                  err_o
);
  localparam int BANKS  = 2 * L3_FUSE_W;
  localparam int BANK_W = $clog2(BANKS);
  localparam int MSL_W  = $clog2(NUM_MSLICE);
  localparam int DSS_W  = $clog2(NUM_DSS);
  localparam int CLS_W  = $clog2(NCLS);
  localparam int SLC_W  = NUM_RNG * ADDR_W;

  logic [NCLS-1:0] cls_hit;
  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    steer_range_match #(
      .ADDR_W (ADDR_W),
      .NUM_RNG(NUM_RNG),
      .LO     (RNG_LO[c*SLC_W +: SLC_W]),
      .HI     (RNG_HI[c*SLC_W +: SLC_W])
    ) u_match (
      .addr_i(offset_i),
      .hit_o (cls_hit[c])
    );
  end

  // lowest class index has highest priority
  logic [CLS_W-1:0] cls_idx;
  logic             cls_none;
  steer_first_set #(.W(NCLS), .IDX_W(CLS_W)) u_cls_pick (
    .vec_i (cls_hit),
    .idx_o (cls_idx),
    .none_o(cls_none)
  );

  logic [BANKS-1:0]      bank_en;
  logic [NUM_MSLICE-1:0] msl_en;
  steer_unit_masks #(
    .L3_FUSE_W (L3_FUSE_W),
    .NUM_DSS   (NUM_DSS),
    .NUM_MSLICE(NUM_MSLICE)
  ) u_masks (
    .l3_fuse_i (l3_fuse_i),
    .dss_en_i  (dss_en_i),
    .meml3_en_i(meml3_en_i),
    .bank_en_o (bank_en),
    .msl_en_o  (msl_en)
  );

  logic [BANK_W-1:0] bank_idx;
  logic [MSL_W-1:0]  msl_idx;
  logic [DSS_W-1:0]  dss_idx;
  logic              bank_none, msl_none, dss_none;

  steer_first_set #(.W(BANKS), .IDX_W(BANK_W)) u_bank_pick (
    .vec_i(bank_en), .idx_o(bank_idx), .none_o(bank_none));
  steer_first_set #(.W(NUM_MSLICE), .IDX_W(MSL_W)) u_msl_pick (
    .vec_i(msl_en), .idx_o(msl_idx), .none_o(msl_none));
  steer_first_set #(.W(NUM_DSS), .IDX_W(DSS_W)) u_dss_pick (
    .vec_i(dss_en_i), .idx_o(dss_idx), .none_o(dss_none));

  steer_cls_e       nx_cls;
  logic [GID_W-1:0] nx_grp;
  logic [IID_W-1:0] nx_inst;
  logic             nx_err;

  always_comb begin
    nx_cls  = cls_none ? CLS_NONE : steer_cls_e'(cls_idx);
    nx_grp  = '0;
    nx_inst = '0;
    nx_err  = 1'b0;
    case (nx_cls)
      CLS_BANK: begin
        nx_inst = IID_W'(bank_idx);
        nx_err  = bank_none;
      end
      CLS_MSL: begin
        nx_grp = GID_W'(msl_idx);
        nx_err = msl_none;
      end
      CLS_NCACH: begin
        nx_grp = GID_W'({msl_idx, 1'b0});
        nx_err = msl_none;
      end
      CLS_DSS: begin
        nx_grp  = GID_W'(dss_idx / DSS_W'(DSS_PER_GRP));
        nx_inst = IID_W'(dss_idx % DSS_W'(DSS_PER_GRP));
        nx_err  = dss_none;
      end
      CLS_ZERO: ;
      default: begin
        nx_grp  = dflt_group_i;
        nx_inst = dflt_inst_i;
      end
    endcase
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hit_o   <= 1'b0;
        class_o <= CLS_NONE;
        group_o <= '0;
        inst_o  <= '0;
        err_o   <= 1'b0;
      end else begin
        hit_o   <= ~cls_none;
        class_o <= nx_cls;
        group_o <= nx_grp;
        inst_o  <= nx_inst;
        err_o   <= nx_err;
      end
    end
  end else begin : g_comb
    assign hit_o   = ~cls_none;
    assign class_o = nx_cls;
    assign group_o = nx_grp;
    assign inst_o  = nx_inst;
    assign err_o   = nx_err;
  end
endmodule

// File: rtl/steer_resolver_chk.sv
`timescale 1ns/1ps
module steer_resolver_chk #(
  parameter int GID_W       = 6,
  parameter int IID_W       = 6,
  parameter int DSS_PER_GRP = 4,
  parameter bit OUT_REG     = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [GID_W-1:0] dflt_group_i,
  input logic [IID_W-1:0] dflt_inst_i,
  input logic             hit_o,
  input logic [2:0]       class_o,
  input logic [GID_W-1:0] group_o,
  input logic [IID_W-1:0] inst_o,
  input logic             err_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  if (OUT_REG) begin : g_seq
    AST_MISS_TAKES_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && !hit_o) |-> (group_o == $past(dflt_group_i) && inst_o == $past(dflt_inst_i))); // R3
  end

  AST_MISS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> class_o == 3'd7); // R3
  AST_HIT_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> class_o <= 3'd4); // R2
  AST_BANK_GROUP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && class_o == 3'd0) |-> group_o == '0); // R4
  AST_NCACH_GROUP_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && class_o == 3'd2) |-> (group_o[0] == 1'b0 && inst_o == '0)); // R6
  AST_DSS_INST_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && class_o == 3'd3) |-> inst_o < IID_W'(DSS_PER_GRP)); // R7
  AST_ZERO_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && class_o == 3'd4) |-> (group_o == '0 && inst_o == '0 && !err_o)); // R8
  AST_ERR_ONLY_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (hit_o && class_o <= 3'd3)); // R9
endmodule

bind steer_resolver steer_resolver_chk #(
  .GID_W      (GID_W),
  .IID_W      (IID_W),
  .DSS_PER_GRP(DSS_PER_GRP),
  .OUT_REG    (OUT_REG)
) u_chk (.*);

// File: tb/sim_steer_resolver.sv
`timescale 1ns/1ps
module sim_steer_resolver;
  typedef struct packed {
    logic       hit;
    logic [2:0] cls;
    logic [5:0] grp;
    logic [5:0] inst;
    logic       err;
  } res_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] offset = '0;
  logic [2:0]  fuse = '0;
  logic [15:0] dss = '0;
  logic [3:0]  meml3 = '0;
  logic [5:0]  dg = '0;
  logic [5:0]  di = '0;
  logic        hit, err;
  logic [2:0]  cls;
  logic [5:0]  grp, inst;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  res_t  exp_q[$];
  int    due_q[$];
  string tag_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  steer_resolver u0 (
    .clk_i(clk), .rst_ni(rst_n), .offset_i(offset), .l3_fuse_i(fuse),
    .dss_en_i(dss), .meml3_en_i(meml3), .dflt_group_i(dg), .dflt_inst_i(di),
    .hit_o(hit), .class_o(cls), .group_o(grp), .inst_o(inst), .err_o(err)
  );

  function automatic bit in_r(logic [23:0] o, logic [23:0] lo, logic [23:0] hi);
    return (o >= lo) && (o <= hi);
  endfunction

  function automatic res_t model(logic [23:0] o, logic [2:0] f, logic [15:0] d,
                                 logic [3:0] m, logic [5:0] g0, logic [5:0] i0);
    res_t r = '0;
    int   bank = -1, msl = -1, ds = -1;
    for (int i = 2; i >= 0; i--) if (f[i]) bank = 2 * i;
    for (int k = 3; k >= 0; k--) if (m[k] || d[4*k +: 4] != 4'd0) msl = k;
    for (int k = 15; k >= 0; k--) if (d[k]) ds = k;
    r.hit = 1'b1;
    if (in_r(o, 24'hB100, 24'hB3FF)) begin
      r.cls = 3'd0; r.err = (bank < 0); r.inst = (bank < 0) ? 6'd0 : 6'(bank);
    end else if (in_r(o, 24'hDD00, 24'hDDFF) || in_r(o, 24'hE900, 24'hFFFF)) begin
      r.cls = 3'd1; r.err = (msl < 0); r.grp = (msl < 0) ? 6'd0 : 6'(msl);
    end else if (in_r(o, 24'hB000, 24'hB0FF) || in_r(o, 24'hD800, 24'hD8FF)) begin
      r.cls = 3'd2; r.err = (msl < 0); r.grp = (msl < 0) ? 6'd0 : 6'(2 * msl);
    end else if (in_r(o, 24'h5500, 24'h7FFF) || in_r(o, 24'h9680, 24'h96FF)) begin
      r.cls = 3'd3; r.err = (ds < 0);
      r.grp  = (ds < 0) ? 6'd0 : 6'(ds / 4);
      r.inst = (ds < 0) ? 6'd0 : 6'(ds % 4);
    end else if (in_r(o, 24'h4000, 24'h4AFF) || in_r(o, 24'hB000, 24'hB3FF)) begin
      r.cls = 3'd4;
    end else begin
      r.hit = 1'b0; r.cls = 3'd7; r.grp = g0; r.inst = i0;
    end
    return r;
  endfunction

  task automatic apply(logic [23:0] o, logic [2:0] f, logic [15:0] d, logic [3:0] m,
                       logic [5:0] g0, logic [5:0] i0, string tag);
    @(negedge clk);
    offset = o; fuse = f; dss = d; meml3 = m; dg = g0; di = i0;
    exp_q.push_back(model(o, f, d, m, g0, i0));
    due_q.push_back(cyc + 1);
    tag_q.push_back(tag);
  endtask

  // monitor: compare each item in the cycle it falls due
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (due_q.size() > 0 && due_q[0] == cyc) begin
        res_t  e = exp_q.pop_front();
        res_t  a = {hit, cls, grp, inst, err};
        string t = tag_q.pop_front();
        void'(due_q.pop_front());
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: actual hit=%b cls=%0d grp=%0d inst=%0d err=%b expected hit=%b cls=%0d grp=%0d inst=%0d err=%b",
                   t, a.hit, a.cls, a.grp, a.inst, a.err, e.hit, e.cls, e.grp, e.inst, e.err);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    dg = 6'd9; di = 6'd5; offset = 24'hB200; fuse = 3'b001;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    // R10 reset state
    if ({hit, cls, grp, inst, err} !== {1'b0, 3'd7, 6'd0, 6'd0, 1'b0}) begin
      errors++;
      $display("FAIL R10 reset: actual hit=%b cls=%0d grp=%0d inst=%0d err=%b expected 0 7 0 0 0",
               hit, cls, grp, inst, err);
    end
    rst_n = 1'b1;

    // R1 inclusive boundaries
    apply(24'hB100, 3'b001, 16'h0001, 4'h1, 6'd9, 6'd5, "R1 bank start");
    apply(24'hB3FF, 3'b001, 16'h0001, 4'h1, 6'd9, 6'd5, "R1 bank end");
    apply(24'hB400, 3'b001, 16'h0001, 4'h1, 6'd9, 6'd5, "R1 past end");
    apply(24'h5500, 3'b001, 16'h0001, 4'h1, 6'd9, 6'd5, "R1 dss start");
    apply(24'h54FF, 3'b001, 16'h0001, 4'h1, 6'd9, 6'd5, "R1 below start");
    apply(24'hD8FF, 3'b001, 16'h0001, 4'h1, 6'd9, 6'd5, "R1 ncach end");
    apply(24'hD900, 3'b001, 16'h0001, 4'h1, 6'd9, 6'd5, "R1 past ncach");
    // R2 priority with overlapping fixed-zero range
    apply(24'hB200, 3'b010, 16'h0010, 4'h0, 6'd1, 6'd1, "R2 bank over zero");
    apply(24'hB050, 3'b010, 16'h0010, 4'h0, 6'd1, 6'd1, "R2 ncach over zero");
    apply(24'hB0FF, 3'b010, 16'h0010, 4'h0, 6'd1, 6'd1, "R2 ncach edge");
    // R3 default pair
    apply(24'h001234, 3'b111, 16'hFFFF, 4'hF, 6'd5, 6'd9, "R3 default a");
    apply(24'h393200, 3'b111, 16'hFFFF, 4'hF, 6'h3F, 6'h2A, "R3 default b");
    // R4 bank pairs
    apply(24'hB180, 3'b100, 16'h0000, 4'h0, 6'd0, 6'd0, "R4 fuse2");
    apply(24'hB180, 3'b110, 16'h0000, 4'h0, 6'd0, 6'd0, "R4 fuse1");
    apply(24'hB180, 3'b101, 16'h0000, 4'h0, 6'd0, 6'd0, "R4 fuse0");
    // R5 memory slice
    apply(24'hDD10, 3'b000, 16'h0100, 4'h0, 6'd0, 6'd0, "R5 via dss");
    apply(24'hF000, 3'b000, 16'h0000, 4'h8, 6'd0, 6'd0, "R5 via meml3");
    apply(24'hE900, 3'b000, 16'h0100, 4'h2, 6'd0, 6'd0, "R5 lowest");
    // R6 near-cache
    apply(24'hD810, 3'b000, 16'h0100, 4'h0, 6'd0, 6'd0, "R6 slice2");
    apply(24'hB010, 3'b000, 16'h0000, 4'h8, 6'd0, 6'd0, "R6 slice3");
    // R7 DSS
    apply(24'h6000, 3'b000, 16'h0400, 4'h0, 6'd0, 6'd0, "R7 idx10");
    apply(24'h9680, 3'b000, 16'h0001, 4'h0, 6'd0, 6'd0, "R7 idx0");
    apply(24'h96FF, 3'b000, 16'h8000, 4'h0, 6'd0, 6'd0, "R7 idx15");
    // R8 fixed zero
    apply(24'h4800, 3'b000, 16'h0000, 4'h0, 6'd7, 6'd7, "R8 empty masks");
    apply(24'h4000, 3'b100, 16'h8000, 4'h8, 6'd7, 6'd7, "R8 full masks");
    // R9 empty masks
    apply(24'hB200, 3'b000, 16'hFFFF, 4'hF, 6'd0, 6'd0, "R9 bank empty");
    apply(24'h7000, 3'b111, 16'h0000, 4'hF, 6'd0, 6'd0, "R9 dss empty");
    apply(24'hDD10, 3'b111, 16'h0000, 4'h0, 6'd0, 6'd0, "R9 msl empty");
    apply(24'h000100, 3'b000, 16'h0000, 4'h0, 6'd3, 6'd4, "R9 default no err");
    // R10 back-to-back changes every cycle
    for (int k = 0; k < 8; k++)
      apply(24'hB100 + 24'(k * 24'h40), 3'(k), 16'(1 << k), 4'(k), 6'(k), 6'(k + 1), "R10 stream");

    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule